// File: doc/BRIEF.md
# Three-Wire Serial Command Receiver

This block is the receive-only serial front end of a display controller. An external host drives three wires: an active-low select, a serial clock and a data line. No wire leads back to the host. The block brings all three wires into the system clock domain and finds the clock edges there. It then assembles bytes, most significant bit first, from the value on the data line at each rising serial-clock edge.

The first byte of every select-low period is a subaddress. Its top bit is a direction flag and the next two bits are a device-select code. When the code matches, the frame is accepted. A write frame then hands each later byte to the core on a parallel bus with a single-cycle strobe. A read frame gives one request pulse and no data. When the code does not match, the rest of the frame is dropped without any output. Raising the select line always ends the frame and clears all partial state.

Top module: `spi3_cmd_rx`

## Requirements
- R1: After reset, data_valid, first_data, read_request, frame_error and frame_active are all 0.
- R2: Bits are taken from sdi_i at rising edges of sck_i, and the first bit taken is bit 7 of the byte.
- R3: When a write frame is accepted, every complete byte after the subaddress appears on data_out, with data_valid high for exactly one clock cycle for each byte.
- R4: first_data is high together with data_valid for the first data byte of an accepted write frame, and is low for every later byte of that frame.
- R5: When bits 6..5 of the subaddress are not binary 01, the frame gives no data_valid, no read_request and no frame_active.
- R6: When the subaddress has bit 7 = 1 and bits 6..5 = 01, the block gives exactly one read_request pulse and no data_valid for the whole frame.
- R7: Bits 4..0 of the subaddress have no effect on acceptance or on the data delivered.
- R8: While cs_n_i is high, the bit count and the frame state are held clear, so the first byte after every falling edge of cs_n_i is treated as a subaddress.
- R9: If cs_n_i rises after 1 to 7 bits of a byte, those bits are discarded (no data_valid) and frame_error pulses high for one cycle. A frame that ends on a byte boundary gives no frame_error.
- R10: frame_active goes high when an accepted subaddress completes, and stays high until cs_n_i rises. Once the rise is seen, frame_active is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| data_out | output | 8 | Last received data byte |
| data_valid | output | 1 | One-cycle strobe when data_out holds a new byte |
| first_data | output | 1 | Marks the first data byte of a frame |
| read_request | output | 1 | One-cycle pulse when an accepted read subaddress completes |
| frame_error | output | 1 | One-cycle pulse when a frame ends mid-byte |
| frame_active | output | 1 | High from an accepted subaddress until the select is released |

## Verification
The assertions depend on slow serial signals. Each serial-clock level must last at least two system clocks, so that a byte takes many cycles and two strobes can never be adjacent. The select line must also stay high for more than one cycle, so that frame_active and the error pulse settle before the next frame starts. The bench meets both conditions: it holds every serial-clock phase and every select-high gap for four or more system clocks. It changes the data line only while the serial clock is low. It sweeps all 256 subaddress values, and then drives frames that end mid-byte.

// File: rtl/spi3_rx_pkg.sv
package spi3_rx_pkg;
  typedef enum logic [1:0] {
    FR_SUBADDR,
    FR_WRITE,
    FR_READ,
    FR_DROP
  } frame_state_e;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi3_shifter.sv
module spi3_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic              partial_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W-1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_shreg;

  assign next_shreg = {shreg[BYTE_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      cnt         <= '0;
      byte_done_o <= 1'b0;
      shreg       <= '0;
      if (rst) byte_o <= '0;
    end else begin
      byte_done_o <= 1'b0;
      if (sck_rise) begin
        shreg <= next_shreg;
        if (cnt == LAST) begin
          cnt         <= '0;
          byte_done_o <= 1'b1;
          byte_o      <= next_shreg;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign partial_o = (cnt != '0);

  // R8: count is cleared whenever the select is released
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0));
  // R3: a byte completion is a single-cycle event
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    byte_done_o |=> !byte_done_o);
endmodule

// File: rtl/spi3_frame_ctl.sv
module spi3_frame_ctl
  import spi3_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [1:0] SEL_CODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              cs_rise,
  input  logic              partial,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_done,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_valid,
  output logic              first_data,
  output logic              read_request,
  output logic              frame_error,
  output logic              frame_active
);
  localparam int RW_BIT  = BYTE_W - 1;
  localparam int SEL_HI  = BYTE_W - 2;
  localparam int SEL_LO  = BYTE_W - 3;

  frame_state_e state;
  logic         first_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= FR_SUBADDR;
      first_pend   <= 1'b0;
      data_out     <= '0;
      data_valid   <= 1'b0;
      first_data   <= 1'b0;
      read_request <= 1'b0;
      frame_error  <= 1'b0;
      frame_active <= 1'b0;
    end else begin
      data_valid   <= 1'b0;
      first_data   <= 1'b0;
      read_request <= 1'b0;
      frame_error  <= cs_rise && partial;
      if (!cs_act) begin
        state        <= FR_SUBADDR;
        first_pend   <= 1'b0;
        frame_active <= 1'b0;
      end else if (byte_done) begin
        case (state)
          FR_SUBADDR: begin
            if (byte_i[SEL_HI:SEL_LO] == SEL_CODE) begin
              frame_active <= 1'b1;
              if (byte_i[RW_BIT]) begin
                state        <= FR_READ;
                read_request <= 1'b1;
              end else begin
                state      <= FR_WRITE;
                first_pend <= 1'b1;
              end
            end else begin
              state <= FR_DROP;
            end
          end
          FR_WRITE: begin
            data_out   <= byte_i;
            data_valid <= 1'b1;
            first_data <= first_pend;
            first_pend <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: strobes are single cycle and only inside an accepted frame
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);
  assert_valid_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> frame_active);
  // R4: first marker only accompanies a strobe
  assert_first_with_valid_R4: assert property (@(posedge clk) disable iff (rst)
    first_data |-> data_valid);
  // R6: read request is a single pulse and never alongside data
  assert_read_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    read_request |=> !read_request);
  assert_read_no_data_R6: assert property (@(posedge clk) disable iff (rst)
    read_request |-> !data_valid);
  // R10: frame activity ends once the release is seen
  assert_active_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !frame_active);
  // R9: error pulse is single cycle
  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    frame_error |=> !frame_error);
endmodule

// File: rtl/spi3_cmd_rx.sv
module spi3_cmd_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [1:0] SEL_CODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_valid,
  output logic              first_data,
  output logic              read_request,
  output logic              frame_error,
  output logic              frame_active
);
  logic [2:0] raw_in, sync_out;
  logic cs_s, sck_s, sdi_s;
  logic cs_d, sck_d;
  logic sck_rise, cs_rise, cs_act;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_done, rx_partial;

  assign raw_in = {cs_n_i, sck_i, sdi_i};

  spi3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_out)
  );

  assign {cs_s, sck_s, sdi_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign sck_rise = sck_s && !sck_d;
  assign cs_rise  = cs_s && !cs_d;
  assign cs_act   = !cs_s;

  spi3_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise), .sdi(sdi_s),
    .byte_o(rx_byte), .byte_done_o(rx_done), .partial_o(rx_partial)
  );

  spi3_frame_ctl #(.BYTE_W(BYTE_W), .SEL_CODE(SEL_CODE)) u_frame (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_rise(cs_rise),
    .partial(rx_partial), .byte_i(rx_byte), .byte_done(rx_done),
    .data_out(data_out), .data_valid(data_valid), .first_data(first_data),
    .read_request(read_request), .frame_error(frame_error),
    .frame_active(frame_active)
  );

  // R2: serial edges are only acted on inside a frame
  assert_edges_gated_R2: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> !cs_s || $past(!cs_s));
endmodule

// File: tb/spi3_cmd_rx_bench.sv
module spi3_cmd_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [7:0] data_out;
  logic data_valid, first_data, read_request, frame_error, frame_active;

  int checks = 0;
  int errors = 0;

  int dv_cnt = 0, rr_cnt = 0, fe_cnt = 0, fa_cnt = 0, fd_cnt = 0;
  logic [7:0] log_byte  [1024];
  logic       log_first [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3_cmd_rx u_spi3_cmd_rx (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .data_out(data_out), .data_valid(data_valid), .first_data(first_data),
    .read_request(read_request), .frame_error(frame_error),
    .frame_active(frame_active)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (data_valid) begin
        if (dv_cnt < 1024) begin
          log_byte[dv_cnt]  <= data_out;
          log_first[dv_cnt] <= first_data;
        end
        dv_cnt <= dv_cnt + 1;
      end
      if (first_data)   fd_cnt <= fd_cnt + 1;
      if (read_request) rr_cnt <= rr_cnt + 1;
      if (frame_error)  fe_cnt <= fe_cnt + 1;
      if (frame_active) fa_cnt <= fa_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic frame_start();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  initial begin
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
    // R1: reset state
    chk(!data_valid, "R1 data_valid", data_valid, 0);
    chk(!first_data, "R1 first_data", first_data, 0);
    chk(!read_request, "R1 read_request", read_request, 0);
    chk(!frame_error, "R1 frame_error", frame_error, 0);
    chk(!frame_active, "R1 frame_active", frame_active, 0);

    // Sweep every subaddress value with two data bytes (R2..R7, R10)
    for (int sa = 0; sa < 256; sa++) begin
      logic [7:0] b0, b1;
      bit acc, rd;
      int dv0, rr0, fe0, fa0, fd0;
      b0 = 8'(sa * 7 + 3);
      b1 = 8'(sa) ^ 8'hA5;
      acc = (sa[6:5] == 2'b01);
      rd  = sa[7];
      dv0 = dv_cnt; rr0 = rr_cnt; fe0 = fe_cnt; fa0 = fa_cnt; fd0 = fd_cnt;
      frame_start();
      send_bits(8'(sa), 8);
      send_bits(b0, 8);
      send_bits(b1, 8);
      frame_end();
      // R3 R5 R7: strobe count follows select code and direction only
      chk(dv_cnt - dv0 == ((acc && !rd) ? 2 : 0), "R3 R5 R7 strobe count",
          dv_cnt - dv0, (acc && !rd) ? 2 : 0);
      if (acc && !rd && dv_cnt - dv0 == 2) begin
        // R2: MSB-first assembly
        chk(log_byte[dv0] == b0, "R2 byte0", log_byte[dv0], b0);
        chk(log_byte[dv0+1] == b1, "R2 byte1", log_byte[dv0+1], b1);
        // R4: first marker only on first byte
        chk(log_first[dv0] && !log_first[dv0+1], "R4 first flags",
            {log_first[dv0], log_first[dv0+1]}, 2);
      end
      chk(fd_cnt - fd0 == ((acc && !rd) ? 1 : 0), "R4 first count",
          fd_cnt - fd0, (acc && !rd) ? 1 : 0);
      // R6: one read pulse for accepted read frames
      chk(rr_cnt - rr0 == ((acc && rd) ? 1 : 0), "R6 read_request count",
          rr_cnt - rr0, (acc && rd) ? 1 : 0);
      // R10: active during accepted frames, cleared after release
      chk((fa_cnt - fa0 > 0) == acc, "R10 frame_active seen",
          fa_cnt - fa0, acc ? 1 : 0);
      chk(!frame_active, "R10 frame_active cleared", frame_active, 0);
      // R9: whole-byte frames raise no error
      chk(fe_cnt == fe0, "R9 no error", fe_cnt - fe0, 0);
    end

    // R9: accepted write frame ending mid-byte
    begin
      int dv0, fe0;
      dv0 = dv_cnt; fe0 = fe_cnt;
      frame_start();
      send_bits(8'h20, 8);
      send_bits(8'h5A, 8);
      send_bits(8'hFF, 5);
      frame_end();
      chk(dv_cnt - dv0 == 1, "R9 partial discarded", dv_cnt - dv0, 1);
      chk(log_byte[dv0] == 8'h5A, "R9 full byte kept", log_byte[dv0], 8'h5A);
      chk(fe_cnt - fe0 == 1, "R9 error pulse", fe_cnt - fe0, 1);
    end

    // R9: dropped frame ending mid-byte still flags error
    begin
      int fe0;
      fe0 = fe_cnt;
      frame_start();
      send_bits(8'h00, 8);
      send_bits(8'hFF, 3);
      frame_end();
      chk(fe_cnt - fe0 == 1, "R9 error in dropped frame", fe_cnt - fe0, 1);
    end

    // R8: aborted subaddress then a fresh frame starts from bit zero
    begin
      int dv0, fe0;
      fe0 = fe_cnt;
      frame_start();
      send_bits(8'hFF, 4);
      frame_end();
      chk(fe_cnt - fe0 == 1, "R8 abort error", fe_cnt - fe0, 1);
      dv0 = dv_cnt;
      frame_start();
      send_bits(8'h3F, 8);
      send_bits(8'hC3, 8);
      frame_end();
      chk(dv_cnt - dv0 == 1, "R8 fresh frame strobe", dv_cnt - dv0, 1);
      chk(log_byte[dv0] == 8'hC3, "R8 fresh frame byte", log_byte[dv0], 8'hC3);
      chk(log_first[dv0], "R8 fresh frame first", log_first[dv0], 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule